// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A base register holds the physical address of the top-level table, and software reloads it when the running process changes. For each request the walker reads one top-level entry and, when that entry is marked valid, one leaf entry. The second read depends on the first. When the walk ends, the block gives one of three results: a physical address, an invalid-address fault, or a fault for a page that is valid but not resident.

The memory side is a simple port. A read request is held until the memory accepts it, and the read data comes back later as a one-cycle response beat. Only one read is in flight at any time. The block takes a new request only while it is idle. It ends every walk with a one-cycle completion pulse that carries the address and a two-bit fault code.

The address split is as follows. Bits [31:22] select the top-level entry, bits [21:12] select the leaf entry, and bits [11:0] are the page offset. Each entry is 4 bytes, so an entry address is the table base plus four times the index. In any entry, bit 0 means valid. In a leaf entry, bit 1 means resident, and bits [31:12] give the physical frame number. In a top-level entry, bits [31:12] give the leaf table base, with the low 12 bits of that base taken as zero.

Top module: `pgwalk_unit`

## Requirements
- R1: During reset and directly after it, `req_ready` is 1, and `mem_req_valid` and `done` are both 0.
- R2: A request is taken only while `req_ready` is 1. From the cycle after it is taken until the walk completes, `req_ready` stays 0.
- R3: The first memory read goes to the base register value plus 4 × va[31:22].
- R4: The second read goes to {top-level entry[31:12], 12'h000} + 4 × va[21:12]. The low 12 bits of the top-level entry play no part in that address.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` does not change.
- R6: If the top-level entry has bit 0 clear, the walk ends with fault code 1 after exactly one memory read.
- R7: If the leaf entry has bit 0 clear, the walk ends with fault code 1 after two reads.
- R8: If the leaf entry has bit 0 set and bit 1 clear, the walk ends with fault code 2 (page not resident).
- R9: If the leaf entry has bits 0 and 1 both set, the walk ends with fault code 0 and `done_pa` = {leaf[31:12], va[11:0]}.
- R10: `done` is high for exactly one cycle per walk, and the walker is idle (`req_ready` = 1) in the cycle after.
- R11: A base load is used by walks taken after the cycle in which it is applied. It does not change a walk already in progress.
- R12: No walk issues more than two reads. Results do not depend on memory stalls or response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ld | input | 1 | Loads `base_val` into the table base register |
| base_val | input | 32 | Physical address of top-level table entry 0 |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| req_va | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Physical address (0 on a fault) |
| done_fault | output | 2 | 0 none, 1 invalid address, 2 not resident |

## Verification
The bench builds the walker with its default parameters: a 10/10/12 address split, 4-byte entries, valid in bit 0 and resident in bit 1. With these values, table slots at both ends of each index range can be placed at known addresses, including index 1023 at each level and an offset of 0xFFF. A second phase adds ready stalls and a three-cycle response delay, which exercises the held-request and waiting states. A base reload in the middle of a walk shows which table each walk used.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ_L0 = 3'd1,
        ST_WAIT_L0 = 3'd2,
        ST_READ_L1 = 3'd3,
        ST_WAIT_L1 = 3'd4,
        ST_DONE    = 3'd5
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE         = 2'd0,
        FLT_INVALID      = 2'd1,
        FLT_NOT_RESIDENT = 2'd2
    } walk_flt_e;

endpackage

// File: rtl/pgwalk_ent_addr.sv
// Entry address generator: table base plus index scaled by the entry size.
module pgwalk_ent_addr #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 10,
    parameter int ENT_BYTES = 4
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] ent_addr
);
    localparam int SHIFT = $clog2(ENT_BYTES);

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled                       = '0;
        scaled[IDX_W+SHIFT-1:SHIFT]  = idx;
        ent_addr                     = tbl_base + scaled;
    end
endmodule

// File: rtl/pgwalk_ent_decode.sv
// Splits a table entry into its flag bits, its frame number and the table base it points to.
module pgwalk_ent_decode #(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 12,
    parameter int VALID_BIT = 0,
    parameter int RES_BIT   = 1
) (
    input  logic [ADDR_W-1:0]       entry,
    output logic                    ent_valid,
    output logic                    ent_resident,
    output logic [ADDR_W-OFF_W-1:0] ent_frame,
    output logic [ADDR_W-1:0]       ent_next_base
);
    always_comb begin
        ent_valid     = entry[VALID_BIT];
        ent_resident  = entry[RES_BIT];
        ent_frame     = entry[ADDR_W-1:OFF_W];
        ent_next_base = {entry[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/pgwalk_unit.sv
module pgwalk_unit
    import pgwalk_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int L0_W      = 10,
    parameter int L1_W      = 10,
    parameter int OFF_W     = 12,
    parameter int ENT_BYTES = 4,
    parameter int VALID_BIT = 0,
    parameter int RES_BIT   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_ld,
    input  logic [PA_W-1:0] base_val,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic [PA_W-1:0] done_pa,
    output logic [1:0]      done_fault
);
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int L1_LSB  = OFF_W;
    localparam int L0_LSB  = OFF_W + L1_W;

    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] addr;
        logic [PA_W-1:0] pa;
        walk_flt_e       flt;
    } walk_reg_t;

    walk_reg_t r_d, r_q;

    logic [PA_W-1:0]    l0_addr;
    logic [PA_W-1:0]    l1_addr;
    logic               ent_valid;
    logic               ent_resident;
    logic [FRAME_W-1:0] ent_frame;
    logic [PA_W-1:0]    ent_next_base;

    pgwalk_ent_addr #(.ADDR_W(PA_W), .IDX_W(L0_W), .ENT_BYTES(ENT_BYTES)) u_l0_addr (
        .tbl_base (r_q.base),
        .idx      (req_va[L0_LSB +: L0_W]),
        .ent_addr (l0_addr)
    );

    pgwalk_ent_addr #(.ADDR_W(PA_W), .IDX_W(L1_W), .ENT_BYTES(ENT_BYTES)) u_l1_addr (
        .tbl_base (ent_next_base),
        .idx      (r_q.va[L1_LSB +: L1_W]),
        .ent_addr (l1_addr)
    );

    pgwalk_ent_decode #(.ADDR_W(PA_W), .OFF_W(OFF_W), .VALID_BIT(VALID_BIT), .RES_BIT(RES_BIT)) u_dec (
        .entry         (mem_rsp_data),
        .ent_valid     (ent_valid),
        .ent_resident  (ent_resident),
        .ent_frame     (ent_frame),
        .ent_next_base (ent_next_base)
    );

    always_comb begin
        r_d = r_q;
        if (base_ld) begin
            r_d.base = base_val;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_va;
                    r_d.addr = l0_addr;
                    r_d.st   = ST_READ_L0;
                end
            end
            ST_READ_L0: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT_L0;
                end
            end
            ST_WAIT_L0: begin
                if (mem_rsp_valid) begin
                    if (!ent_valid) begin
                        r_d.flt = FLT_INVALID;
                        r_d.pa  = '0;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.addr = l1_addr;
                        r_d.st   = ST_READ_L1;
                    end
                end
            end
            ST_READ_L1: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT_L1;
                end
            end
            ST_WAIT_L1: begin
                if (mem_rsp_valid) begin
                    if (!ent_valid) begin
                        r_d.flt = FLT_INVALID;
                        r_d.pa  = '0;
                    end else if (!ent_resident) begin
                        r_d.flt = FLT_NOT_RESIDENT;
                        r_d.pa  = '0;
                    end else begin
                        r_d.flt = FLT_NONE;
                        r_d.pa  = {ent_frame, r_q.va[OFF_W-1:0]};
                    end
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready     = (r_q.st == ST_IDLE);
        mem_req_valid = (r_q.st == ST_READ_L0) || (r_q.st == ST_READ_L1);
        mem_req_addr  = r_q.addr;
        done          = (r_q.st == ST_DONE);
        done_pa       = r_q.pa;
        done_fault    = r_q.flt;
    end

    // Reads issued since the current walk was taken (checking aid only).
    logic [1:0] rd_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
        end else if (req_valid && req_ready) begin
            rd_cnt_q <= '0;
        end else if (mem_req_valid && mem_req_ready && rd_cnt_q != 2'd3) begin
            rd_cnt_q <= rd_cnt_q + 2'd1;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5

    AST_L0_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done && rd_cnt_q == 2'd1 |-> done_fault == FLT_INVALID); // R6

    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault == FLT_NONE |-> done_pa[OFF_W-1:0] == r_q.va[OFF_W-1:0]); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R10

    AST_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_cnt_q == 2'd1 || rd_cnt_q == 2'd2); // R12

endmodule

// File: tb/sim_pgwalk_unit.sv
module sim_pgwalk_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_ld;
    logic [31:0] base_val;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_va;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [31:0] done_pa;
    logic [1:0]  done_fault;

    pgwalk_unit u0 (
        .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_val(base_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_pa(done_pa),
        .done_fault(done_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  flt;
        int          nrd;
        logic [31:0] a0;
        logic [31:0] a1;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [logic [31:0]];
    int          total = 0;
    int          bad = 0;
    logic [31:0] rd_log [64];
    int          rd_total = 0;
    int          rd_mark = 0;
    int          lat = 0;
    bit          stall = 0;
    logic [31:0] cur_base = 32'h0;

    function automatic logic [31:0] mrd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t ref_walk(logic [31:0] b, logic [31:0] va, string tag);
        exp_t        e;
        logic [31:0] top, leaf;
        e.tag = tag;
        e.a1  = 32'h0;
        e.pa  = 32'h0;
        e.a0  = b + {20'h0, va[31:22], 2'b00};
        top   = mrd(e.a0);
        e.nrd = 1;
        if (!top[0]) begin
            e.flt = 2'd1;
        end else begin
            e.nrd = 2;
            e.a1  = {top[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
            leaf  = mrd(e.a1);
            if (!leaf[0])      e.flt = 2'd1;
            else if (!leaf[1]) e.flt = 2'd2;
            else begin
                e.flt = 2'd0;
                e.pa  = {leaf[31:12], va[11:0]};
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] mkva(int i0, int i1, int off);
        return {i0[9:0], i1[9:0], off[11:0]};
    endfunction

    // Memory model: one read in flight, optional stalls and latency.
    int          cyc = 0;
    bit          pend = 0;
    int          cd = 0;
    logic [31:0] pend_addr;
    bit          prev_stall = 0;
    logic [31:0] prev_addr;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            pend = 0; mem_rsp_valid = 0; mem_req_ready = 1; prev_stall = 0;
        end else begin
            if (prev_stall) begin
                chk(mem_req_valid && mem_req_addr == prev_addr, "R5", "held request address",
                    mem_req_addr, prev_addr);
            end
            mem_rsp_valid = 0;
            if (pend) begin
                if (cd == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = mrd(pend_addr);
                    pend = 0;
                end else begin
                    cd--;
                end
            end
            mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; cd = lat; pend_addr = mem_req_addr;
                rd_log[rd_total % 64] = mem_req_addr;
                rd_total++;
            end
        end
    end

    // Monitor: pops the scoreboard at every completion.
    bit prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                chk(!prev_done, "R10", "done longer than one cycle", {31'h0, prev_done}, 32'h0);
                if (sb.size() == 0) begin
                    chk(0, "R10", "done with no walk pending", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    int   n;
                    e = sb.pop_front();
                    n = rd_total - rd_mark;
                    chk(done_fault == e.flt, e.tag, "fault code", {30'h0, done_fault}, {30'h0, e.flt});
                    chk(done_pa == e.pa, e.tag, "physical address", done_pa, e.pa);
                    chk(n == e.nrd, (e.nrd == 1) ? "R6" : "R12", "read count", n, e.nrd);
                    if (n >= 1) chk(rd_log[rd_mark % 64] == e.a0, "R3", "first read address",
                                    rd_log[rd_mark % 64], e.a0);
                    if (n >= 2 && e.nrd == 2) chk(rd_log[(rd_mark + 1) % 64] == e.a1, "R4",
                                    "second read address", rd_log[(rd_mark + 1) % 64], e.a1);
                    rd_mark = rd_total;
                end
            end else if (prev_done) begin
                chk(req_ready, "R10", "idle after done", {31'h0, req_ready}, 32'h1);
            end
            prev_done = done;
        end
    end

    task automatic load_base(logic [31:0] b);
        base_ld = 1; base_val = b;
        @(negedge clk);
        base_ld = 0;
        cur_base = b;
    endtask

    task automatic walk(logic [31:0] va, string tag, bit midload = 0, logic [31:0] nb = 0);
        while (!req_ready) @(negedge clk);
        sb.push_back(ref_walk(cur_base, va, tag));
        req_valid = 1; req_va = va;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2", "busy after accept", {31'h0, req_ready}, 32'h0);
        if (midload) load_base(nb);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R12 watchdog expired act=0 exp=1");
        summary();
    end

    initial begin
        rst_n = 0; base_ld = 0; base_val = 0; req_valid = 0; req_va = 0;
        mem_req_ready = 1; mem_rsp_valid = 0; mem_rsp_data = 0;
        // base A at 0x0010_0000
        mem[32'h0010_0000 + 5*4]    = 32'h0020_0001;
        mem[32'h0010_0000 + 2*4]    = 32'h0020_0FF1;
        mem[32'h0010_0000 + 1023*4] = 32'h0030_0001;
        mem[32'h0020_0000 + 7*4]    = 32'hABCD_E003;
        mem[32'h0020_0000 + 8*4]    = 32'h1234_5001;
        mem[32'h0020_0000 + 1023*4] = 32'hFFFF_F003;
        mem[32'h0030_0000]          = 32'h0000_1003;
        // base B at 0x0040_0000
        mem[32'h0040_0000 + 5*4]    = 32'h0050_0001;
        mem[32'h0050_0000 + 7*4]    = 32'h7777_7003;

        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !done, "R1", "state in reset",
            {29'h0, req_ready, mem_req_valid, done}, 32'h4);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !done, "R1", "state after reset",
            {29'h0, req_ready, mem_req_valid, done}, 32'h4);

        load_base(32'h0010_0000);
        walk(mkva(5, 7, 'h123), "R9");
        walk(mkva(5, 8, 'h456), "R8");
        walk(mkva(5, 9, 'h001), "R7");
        walk(mkva(6, 7, 'h789), "R6");
        walk(mkva(1023, 0, 'hFFF), "R9");
        walk(mkva(5, 1023, 'h000), "R9");
        walk(mkva(2, 7, 'hABC), "R4");

        stall = 1; lat = 3;
        walk(mkva(5, 7, 'h321), "R12");
        walk(mkva(5, 8, 'h654), "R12");
        walk(mkva(6, 0, 'h000), "R6");

        stall = 0; lat = 1;
        walk(mkva(5, 7, 'h0AA), "R11", 1, 32'h0040_0000);
        walk(mkva(5, 7, 'h0AA), "R11");

        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        summary();
    end
endmodule